// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces the data memory address for a 16-bit fixed-point DSP core. It keeps four register sets, each with an index, a modify step, a buffer length and a buffer base. On every cycle it forms a 24-bit word address from the set that the operation selects. The address is combinational, so a memory access can use it in the same cycle. When the mode calls for an update, the new index value is committed at the next clock edge.

The upper 8 address bits select one of 256 pages of 64K words, and the lower 16 bits are the offset within that page. The block supports six ways of forming an address:

- plain indirect;
- indexed with a signed immediate offset;
- post-modify by the set's modify register;
- post-modify by a signed immediate;
- circular wrap within a buffer;
- bit-reversed offset output for FFT data ordering.

A host bus can write any register of any set.

Top module: `dag_unit`

## Requirements
- R1: After reset every register of every set is zero, so addr_out and index_next are zero for every op_sel in modes 0 and 2.
- R2: A host write with wr_en high stores wr_data at the clock edge. wr_kind selects the register: 0 index, 1 modify, 2 length, 3 base. wr_sel selects the set. The index register is visible on addr_out from the next cycle on.
- R3: Mode 0 (indirect) outputs the selected index on addr_out and leaves it unchanged. Mode codes 5 to 7 behave the same way.
- R4: Mode 1 (indexed) outputs index plus the 16-bit op_imm sign-extended to 24 bits, modulo 2^24. The index is left unchanged.
- R5: Mode 2 (post-modify by register) outputs the index and then replaces it with index plus the set's modify register, modulo 2^24.
- R6: Mode 3 (post-modify by immediate) outputs the index and then replaces it with index plus sign-extended op_imm.
- R7: In modes 2 and 3 with a non-zero length, an updated index at or above base+length has length subtracted.
- R8: In modes 2 and 3 with a non-zero length, an updated index below base has length added.
- R9: A length of zero disables the wrap, and the update is a plain modulo-2^24 sum.
- R10: Mode 4 (bit-reversed) outputs the page bits of the index unchanged and the 16 offset bits in reversed order. The index is then updated by the modify register with no wrap.
- R11: addr_out and index_next follow the inputs in the same cycle. When op_valid is high in modes 2 to 4, index_next is committed to the selected index at the clock edge.
- R12: When a host write to an index register and an update of that same register fall in one cycle, the host value is stored.
- R13: With op_valid low, no index register changes other than by a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Commit the address operation's index update |
| op_mode | input | 3 | Addressing mode code (0 to 4 used) |
| op_sel | input | 2 | Register set used by the operation |
| op_imm | input | 16 | Signed immediate offset or step |
| wr_en | input | 1 | Host register write strobe |
| wr_kind | input | 2 | Register written: 0 index, 1 modify, 2 length, 3 base |
| wr_sel | input | 2 | Register set written |
| wr_data | input | 24 | Host write data |
| addr_out | output | 24 | Effective address |
| index_next | output | 24 | Updated index value for the selected set |

## Verification
A host write to an index register and a post-modify of that same register can land in the same cycle. The bench provokes this by driving a mode-2 operation and an index write to one set together. It then judges the result by reading that index back through addr_out on the next cycle, where the host value must appear. Every cycle, including random runs where circular updates cross the buffer edge in both directions, is compared against a behavioural model that uses wide integer arithmetic.

// File: rtl/dag_unit.sv
module dag_unit #(
  parameter int AW    = 24,
  parameter int NSETS = 4,
  parameter int IMMW  = 16,
  parameter int PAGEW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [2:0]               op_mode,
  input  logic [$clog2(NSETS)-1:0] op_sel,
  input  logic [IMMW-1:0]          op_imm,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [$clog2(NSETS)-1:0] wr_sel,
  input  logic [AW-1:0]            wr_data,
  output logic [AW-1:0]            addr_out,
  output logic [AW-1:0]            index_next
);
  localparam int OFFW = AW - PAGEW;
  localparam logic [2:0] M_IND = 3'd0, M_OFS = 3'd1, M_PREG = 3'd2, M_PIMM = 3'd3, M_BREV = 3'd4;

  logic [NSETS-1:0][AW-1:0] idx_q, mod_q, len_q, base_q;

  logic [AW-1:0] cur_i, cur_m, cur_l, cur_b, imm_ext, step, sum, wrapped;
  logic [OFFW-1:0] rev_off;
  logic [AW:0] limit;
  logic circ, upd;

  assign cur_i   = idx_q[op_sel];
  assign cur_m   = mod_q[op_sel];
  assign cur_l   = len_q[op_sel];
  assign cur_b   = base_q[op_sel];
  assign imm_ext = {{(AW-IMMW){op_imm[IMMW-1]}}, op_imm};
  assign step    = (op_mode == M_PIMM) ? imm_ext : cur_m;
  assign sum     = cur_i + step;
  assign limit   = {1'b0, cur_b} + {1'b0, cur_l};
  assign circ    = (op_mode == M_PREG || op_mode == M_PIMM) && (cur_l != '0);
  assign upd     = (op_mode == M_PREG) || (op_mode == M_PIMM) || (op_mode == M_BREV);

  assign wrapped = ({1'b0, sum} >= limit) ? sum - cur_l :
                   (sum < cur_b)          ? sum + cur_l : sum;

  for (genvar k = 0; k < OFFW; k++) begin : g_rev
    assign rev_off[k] = cur_i[OFFW-1-k];
  end

  assign index_next = !upd ? cur_i : (circ ? wrapped : sum);
  assign addr_out   = (op_mode == M_OFS)  ? cur_i + imm_ext :
                      (op_mode == M_BREV) ? {cur_i[AW-1:OFFW], rev_off} : cur_i;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    wire hit = wr_en && (wr_sel == s);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[s]  <= '0;
        mod_q[s]  <= '0;
        len_q[s]  <= '0;
        base_q[s] <= '0;
      end else begin
        if (hit && wr_kind == 2'd0)                  idx_q[s] <= wr_data;
        else if (op_valid && upd && op_sel == s)     idx_q[s] <= index_next;
        if (hit && wr_kind == 2'd1) mod_q[s]  <= wr_data;
        if (hit && wr_kind == 2'd2) len_q[s]  <= wr_data;
        if (hit && wr_kind == 2'd3) base_q[s] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dag_unit_chk.sv
module dag_unit_chk #(
  parameter int AW    = 24,
  parameter int NSETS = 4,
  parameter int PAGEW = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_valid,
  input logic [2:0]               op_mode,
  input logic [$clog2(NSETS)-1:0] op_sel,
  input logic                     wr_en,
  input logic [1:0]               wr_kind,
  input logic [$clog2(NSETS)-1:0] wr_sel,
  input logic [AW-1:0]            wr_data,
  input logic [AW-1:0]            addr_out,
  input logic [AW-1:0]            index_next,
  input logic [NSETS-1:0][AW-1:0] idx_q,
  input logic [NSETS-1:0][AW-1:0] len_q,
  input logic [NSETS-1:0][AW-1:0] base_q
);
  localparam int OFFW = AW - PAGEW;
  logic idx_wr, clash;
  logic [AW:0] top_sel;
  assign idx_wr  = wr_en && wr_kind == 2'd0;
  assign clash   = idx_wr && wr_sel == op_sel;
  assign top_sel = {1'b0, base_q[op_sel]} + {1'b0, len_q[op_sel]};

  assert_host_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q[$past(wr_sel)] == $past(wr_data));

  assert_index_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode <= 3'd1 && !clash) |=> idx_q[$past(op_sel)] == $past(idx_q[op_sel]));

  assert_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode >= 3'd2 && op_mode <= 3'd4 && !clash) |=> idx_q[$past(op_sel)] == $past(index_next));

  // covers R8 as well as R7: an in-buffer index stays in the buffer
  assert_in_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_mode == 3'd2 || op_mode == 3'd3) && len_q[op_sel] != '0 &&
     idx_q[op_sel] >= base_q[op_sel] && {1'b0, idx_q[op_sel]} < top_sel)
    |-> (index_next >= base_q[op_sel] && {1'b0, index_next} < top_sel));

  assert_page_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd4) |-> addr_out[AW-1:OFFW] == idx_q[op_sel][AW-1:OFFW]);

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> $stable(idx_q));
endmodule

bind dag_unit dag_unit_chk #(.AW(AW), .NSETS(NSETS), .PAGEW(PAGEW)) u_chk (.*);

// File: tb/dag_unit_test.sv
module dag_unit_test;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, wr_en = 0;
  logic [2:0] op_mode = 0;
  logic [1:0] op_sel = 0, wr_kind = 0, wr_sel = 0;
  logic [15:0] op_imm = 0;
  logic [23:0] wr_data = 0, addr_out, index_next;

  dag_unit uut (.*);

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  longint mi[4], mm[4], ml[4], mb[4];

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%06h expected=%06h", req, what, act, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    return (v >= (64'sd1 << (w-1))) ? v - (64'sd1 << w) : v;
  endfunction

  task automatic cyc(input bit ov, input int md, input int sel, input longint imm,
                     input bit we, input int wk, input int ws, input longint wd, input string req);
    longint n, st, a;
    logic [23:0] ea, en, iv;
    string tag;
    @(negedge clk);
    op_valid = ov; op_mode = 3'(md); op_sel = 2'(sel); op_imm = 16'(imm);
    wr_en = we; wr_kind = 2'(wk); wr_sel = 2'(ws); wr_data = 24'(wd);
    #1;
    tag = req;
    st = (md == 3) ? sx(imm & 16'hFFFF, 16) : sx(mm[sel], 24);
    n = mi[sel] + st;
    if (md == 2 || md == 3) begin
      if (tag == "") tag = (md == 2) ? "R5" : "R6";
      if (ml[sel] != 0) begin
        if (n >= mb[sel] + ml[sel]) begin n -= ml[sel]; if (req == "") tag = "R7"; end
        else if (n < mb[sel]) begin n += ml[sel]; if (req == "") tag = "R8"; end
      end else if (req == "") tag = "R9";
    end
    a = mi[sel];
    iv = 24'(mi[sel]);
    if (md == 1) a = mi[sel] + sx(imm & 16'hFFFF, 16);
    if (md == 4) for (int k = 0; k < 16; k++) a = (k == 0 ? (a & 64'hFF0000) : a) | (longint'(iv[15-k]) << k);
    if (tag == "") tag = (md == 1) ? "R4" : (md == 4) ? "R10" : "R3";
    ea = 24'(a);
    en = (md >= 2 && md <= 4) ? 24'(n) : iv;
    check(addr_out, ea, tag, "addr_out");
    check(index_next, en, tag == "R1" ? "R1" : "R11", "index_next");
    if (ov && md >= 2 && md <= 4) mi[sel] = en;
    if (we) begin
      case (wk)
        0: mi[ws] = wd & 24'hFFFFFF;
        1: mm[ws] = wd & 24'hFFFFFF;
        2: ml[ws] = wd & 24'hFFFFFF;
        default: mb[ws] = wd & 24'hFFFFFF;
      endcase
    end
  endtask

  task automatic wr(input int k, input int s, input longint d);
    cyc(0, 0, s, 0, 1, k, s, d, "R2");
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin mi[s] = 0; mm[s] = 0; ml[s] = 0; mb[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, s, 0, 0, 0, 0, 0, "R1");
      cyc(0, 2, s, 0, 0, 0, 0, 0, "R1");
    end
    wr(3, 0, 24'h000100); wr(2, 0, 10); wr(1, 0, 3); wr(0, 0, 24'h000105);
    wr(1, 1, 24'hFFFFFB); wr(0, 1, 24'h3F0010);
    wr(3, 2, 24'h012340); wr(2, 2, 16); wr(1, 2, 4); wr(0, 2, 24'h012342);
    wr(3, 3, 24'hAB0000); wr(2, 3, 7); wr(1, 3, 24'hFFFFFE); wr(0, 3, 24'hAB0003);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 6, 2, 0, 0, 0, 0, 0, "R3");
    cyc(1, 1, 1, 16'h8000, 0, 0, 0, 0, "R4");
    cyc(1, 1, 2, 16'h0010, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R4");
    repeat (5) cyc(1, 2, 0, 0, 0, 0, 0, 0, "");
    repeat (4) cyc(1, 2, 3, 0, 0, 0, 0, 0, "");
    repeat (3) cyc(1, 2, 1, 0, 0, 0, 0, 0, "");
    cyc(1, 3, 2, 16'hFFFD, 0, 0, 0, 0, "");
    cyc(1, 3, 2, 7, 0, 0, 0, 0, "");
    cyc(1, 3, 2, 16'hFFF3, 0, 0, 0, 0, "");
    cyc(1, 3, 2, 15, 0, 0, 0, 0, "");
    repeat (3) cyc(0, 2, 0, 0, 0, 0, 0, 0, "R13");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R13");
    wr(1, 1, 24'h004000); wr(0, 1, 24'h3F0000);
    repeat (5) cyc(1, 4, 1, 0, 0, 0, 0, 0, "R10");
    cyc(1, 4, 2, 0, 0, 0, 0, 0, "R10");
    wr(0, 2, 24'h012345);
    cyc(1, 2, 0, 0, 1, 0, 0, 24'h000107, "R12");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R12");
    wr(1, 1, 24'hFFFFFB);
    for (int t = 0; t < 400; t++) begin
      int md, sel;
      longint imm;
      md = $urandom % 5;
      sel = (md == 4) ? 1 : $urandom % 4;
      if (ml[sel] != 0) imm = longint'($urandom % (2 * ml[sel] - 1)) - (ml[sel] - 1);
      else imm = $urandom % 65536;
      cyc($urandom % 4 != 0, md, sel, imm & 16'hFFFF, 0, 0, 0, 0, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule